// File: doc/BRIEF.md
# Full-Frame CCD Readout Timing Generator

This block produces the logic-level clock pattern for a two-phase full-frame CCD whose four corner outputs all run from one shared set of clocks. After a start strobe it keeps both vertical phases low for a programmable exposure, counted in system clock cycles. It then reads the frame line by line. Each line starts with a vertical transfer made of three equal pulse slots. A horizontal setup gap follows. Then a fixed number of pixel periods is clocked out on the complementary horizontal phases.

The reset gate pulse repeats once per pixel period and never stops, even when no line is being read. Its phase is restarted at the first pixel of every line, so every line has the same pixel grid. A pixel-valid strobe marks one cycle in each pixel period, at a fixed offset from the start of the reset pulse, so that a downstream converter can capture on it. All durations are parameters in system clock cycles. The drive levels and analog sampling live outside this block.

Top module: `ccd_frame_timer`

## Requirements
- R1: Out of reset, and while the exposure count runs after a start, `v1` and `v2` are both low, `frame_active` is low and `h1` is parked high. Exposure lasts `integ_cycles` cycles, counted from the clock edge that captures `start`.
- R2: Each vertical transfer lasts 3*V_CYC cycles. `v1` is high for the first V_CYC cycles, `v2` is high for the next V_CYC cycles, and both are low for the last V_CYC cycles. `v1` and `v2` are never high together.
- R3: `h1` and `h1_last` stay high through the whole vertical transfer and the setup gap, so both are high at the cycle in which `v2` falls.
- R4: `line_active` rises exactly HS_CYC cycles after the vertical transfer ends.
- R5: While `line_active` is high, each pixel period lasts PIX_CYC cycles. `h1` is high for the first PIX_CYC/2 cycles of the period, `h2` is always the complement of `h1`, and `h1_last` equals `h1`. `line_active` stays high for PIXELS*PIX_CYC cycles.
- R6: The interval between consecutive rising edges of `v1` within a frame is exactly 3*V_CYC + HS_CYC + PIXELS*PIX_CYC cycles.
- R7: `rst_gate` is high for RST_W cycles out of every PIX_CYC cycles at all times, including idle. Its period restarts in the first cycle of each line's readout.
- R8: `pix_valid` is high only while `line_active` is high. It is high once per pixel period, in cycle VAL_OFS of that period, where cycle 0 is the first cycle of the reset pulse.
- R9: A frame contains LINES line readouts. After the last one, the block returns to idle with `frame_active` low.
- R10: A `start` that arrives while a frame is in exposure or readout has no effect. The frame keeps its timing, and no new frame follows it.
- R11: With `integ_cycles` equal to 0, `v1` is high in the cycle right after the edge that captures `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame request; honoured only when idle |
| integ_cycles | input | INT_W | Exposure length in clock cycles |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h1_last | output | 1 | Last horizontal gate, follows `h1` |
| rst_gate | output | 1 | Output node reset pulse |
| frame_active | output | 1 | High from the first vertical transfer to the end of the last line |
| line_active | output | 1 | High during pixel readout of a line |
| pix_valid | output | 1 | One-cycle sample strobe per pixel period |

## Verification
The hardest situation to reach is a start request that arrives while the block is busy. Such a request must leave the timing of the running frame unchanged, and it must not queue a second frame. The stimulus asserts `start` in the middle of the exposure count and in the middle of line readouts. The frame is then compared cycle by cycle against an arithmetic model of the line formula, and the bench checks that the outputs stay quiet after the last line. A second hard case is zero exposure, which the bench covers so that the path that skips the exposure count and begins the vertical transfer at once is exercised.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INTEG = 3'd1,
        ST_VXFER = 3'd2,
        ST_HSET  = 3'd3,
        ST_HREAD = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ccd_tg_pixclk.sv
// Pixel-period counter: drives the reset gate, the horizontal half flag
// and the sample strobe; restarts its period at the start of each line.
module ccd_tg_pixclk #(
    parameter int PIX_CYC = 66,
    parameter int RST_W   = 4,
    parameter int VAL_OFS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic rg_o,
    output logic first_half_o,
    output logic strobe_o
);
    localparam int PW = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
    localparam logic [PW-1:0] PC_LAST = PW'(PIX_CYC - 1);

    typedef struct packed {
        logic [PW-1:0] pc;
    } pix_reg_t;

    pix_reg_t pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (restart_i || pix_q.pc == PC_LAST) pix_d.pc = '0;
        else                                  pix_d.pc = pix_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign rg_o         = pix_q.pc < PW'(RST_W);
    assign first_half_o = pix_q.pc < PW'(PIX_CYC / 2);
    assign strobe_o     = pix_q.pc == PW'(VAL_OFS);

    // R7: the counter never leaves its period
    p_pc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_q.pc <= PC_LAST);
    // R7: a restart puts the next cycle at the head of a reset pulse
    p_restart_rg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> rg_o);
endmodule

// File: rtl/ccd_tg_seq.sv
// Frame sequencer: exposure, vertical transfer, setup gap, line readout.
module ccd_tg_seq
    import ccd_tg_pkg::*;
#(
    parameter int V_CYC   = 6000,
    parameter int HS_CYC  = 2000,
    parameter int PIX_CYC = 66,
    parameter int PIXELS  = 1050,
    parameter int LINES   = 1046,
    parameter int INT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [INT_W-1:0] integ_i,
    output seq_state_e       state_o,
    output logic             v1_o,
    output logic             v2_o,
    output logic             read_go_o
);
    localparam int LINE_CYC = 3 * V_CYC + HS_CYC + PIXELS * PIX_CYC;
    localparam int CLW      = $clog2(LINE_CYC + 1);
    localparam int TMR_W    = (INT_W > CLW) ? INT_W : CLW;
    localparam int LN_W     = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [TMR_W-1:0] VX_LAST = TMR_W'(3 * V_CYC - 1);
    localparam logic [TMR_W-1:0] HS_LAST = TMR_W'(HS_CYC - 1);
    localparam logic [TMR_W-1:0] RD_LAST = TMR_W'(PIXELS * PIX_CYC - 1);
    localparam logic [TMR_W-1:0] V_ONE   = TMR_W'(V_CYC);
    localparam logic [TMR_W-1:0] V_TWO   = TMR_W'(2 * V_CYC);
    localparam logic [LN_W-1:0]  LN_LAST = LN_W'(LINES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [TMR_W-1:0] tmr;
        logic [LN_W-1:0]  line;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     go_d;

    always_comb begin
        seq_d = seq_q;
        go_d  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.line = '0;
                    if (integ_i == '0) begin
                        seq_d.st  = ST_VXFER;
                        seq_d.tmr = VX_LAST;
                    end else begin
                        seq_d.st  = ST_INTEG;
                        seq_d.tmr = TMR_W'(integ_i) - TMR_W'(1);
                    end
                end
            end
            ST_INTEG: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = ST_VXFER;
                    seq_d.tmr = VX_LAST;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_VXFER: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = ST_HSET;
                    seq_d.tmr = HS_LAST;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_HSET: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = ST_HREAD;
                    seq_d.tmr = RD_LAST;
                    go_d      = 1'b1;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_HREAD: begin
                if (seq_q.tmr == '0) begin
                    if (seq_q.line == LN_LAST) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.st   = ST_VXFER;
                        seq_d.tmr  = VX_LAST;
                        seq_d.line = seq_q.line + 1'b1;
                    end
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.tmr  <= '0;
            seq_q.line <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o   = seq_q.st;
    assign read_go_o = go_d;
    assign v1_o      = (seq_q.st == ST_VXFER) && (seq_q.tmr >= V_TWO);
    assign v2_o      = (seq_q.st == ST_VXFER) && (seq_q.tmr >= V_ONE) && (seq_q.tmr < V_TWO);

    // R9: line index stays within the frame
    p_line_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.line <= LN_LAST);
    // R4: vertical transfer hands over to the setup gap
    p_vx_to_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_VXFER && seq_q.tmr == '0) |=> seq_q.st == ST_HSET);
    // R10: a start mid-line does not disturb readout
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seq_q.st == ST_HREAD && seq_q.tmr != '0) |=> seq_q.st == ST_HREAD);
endmodule

// File: rtl/ccd_frame_timer.sv
module ccd_frame_timer
    import ccd_tg_pkg::*;
#(
    parameter int V_CYC   = 6000,
    parameter int HS_CYC  = 2000,
    parameter int PIX_CYC = 66,
    parameter int PIXELS  = 1050,
    parameter int LINES   = 1046,
    parameter int RST_W   = 4,
    parameter int VAL_OFS = 8,
    parameter int INT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [INT_W-1:0] integ_cycles,
    output logic             v1,
    output logic             v2,
    output logic             h1,
    output logic             h2,
    output logic             h1_last,
    output logic             rst_gate,
    output logic             frame_active,
    output logic             line_active,
    output logic             pix_valid
);
    seq_state_e st;
    logic       read_go;
    logic       half;
    logic       strobe;

    ccd_tg_seq #(
        .V_CYC(V_CYC), .HS_CYC(HS_CYC), .PIX_CYC(PIX_CYC),
        .PIXELS(PIXELS), .LINES(LINES), .INT_W(INT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .integ_i(integ_cycles),
        .state_o(st), .v1_o(v1), .v2_o(v2), .read_go_o(read_go)
    );

    ccd_tg_pixclk #(
        .PIX_CYC(PIX_CYC), .RST_W(RST_W), .VAL_OFS(VAL_OFS)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .restart_i(read_go),
        .rg_o(rst_gate), .first_half_o(half), .strobe_o(strobe)
    );

    always_comb begin
        line_active  = (st == ST_HREAD);
        frame_active = (st == ST_VXFER) || (st == ST_HSET) || (st == ST_HREAD);
        h1           = line_active ? half : 1'b1;
        h2           = ~h1;
        h1_last      = h1;
        pix_valid    = line_active && strobe;
    end

    // R3: line lands in the horizontal register on the v2 fall
    p_v2_fall_h1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v2) |-> (h1 && h1_last));
    // R1: vertical clocks quiet outside a frame
    p_vert_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> (!v1 && !v2));
    // R2: vertical phases never overlap
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1 && v2));
    // R8: sample strobe only inside readout
    p_valid_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> line_active);
    // R4: readout begins with the vertical clocks already low
    p_read_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_active) |-> $past(!v1 && !v2));
endmodule

// File: tb/sim_ccd_frame_timer.sv
`timescale 1ns/1ps
module sim_ccd_frame_timer;
    localparam int V_CYC   = 3;
    localparam int HS_CYC  = 2;
    localparam int PIX_CYC = 4;
    localparam int PIXELS  = 5;
    localparam int LINES   = 3;
    localparam int RST_W   = 1;
    localparam int VAL_OFS = 2;
    localparam int INT_W   = 16;
    localparam int LINE_CYC = 3 * V_CYC + HS_CYC + PIXELS * PIX_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [INT_W-1:0] integ_cycles = '0;
    logic v1, v2, h1, h2, h1_last, rst_gate, frame_active, line_active, pix_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ccd_frame_timer #(
        .V_CYC(V_CYC), .HS_CYC(HS_CYC), .PIX_CYC(PIX_CYC), .PIXELS(PIXELS),
        .LINES(LINES), .RST_W(RST_W), .VAL_OFS(VAL_OFS), .INT_W(INT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .integ_cycles(integ_cycles),
        .v1(v1), .v2(v2), .h1(h1), .h2(h2), .h1_last(h1_last),
        .rst_gate(rst_gate), .frame_active(frame_active),
        .line_active(line_active), .pix_valid(pix_valid)
    );

    task automatic chk(input logic act, input logic exp, input string req,
                       input string nm, input int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, nm, n, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req, input string nm);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, nm, act, exp);
        end
    endtask

    // One frame compared against the arithmetic model; inj is the cycle
    // at which a busy start is injected (negative for none).
    task automatic run_frame(input int integ, input int inj);
        int last_rise = -1;
        logic prev_v1 = 1'b0;
        int total = integ + LINES * LINE_CYC + 6;
        int rises = 0;
        integ_cycles = INT_W'(integ);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < total; n++) begin
            logic ev1 = 1'b0, ev2 = 1'b0, eh1 = 1'b1, efa = 1'b0, ela = 1'b0;
            logic eval = 1'b0, erg = 1'b0;
            bit in_read = 1'b0;
            string rq = "R1";
            if (n >= integ && n < integ + LINES * LINE_CYC) begin
                int m = n - integ;
                int o = m % LINE_CYC;
                efa = 1'b1;
                rq = "R2";
                if (o < V_CYC) ev1 = 1'b1;
                else if (o < 2 * V_CYC) ev2 = 1'b1;
                if (o >= 3 * V_CYC + HS_CYC) begin
                    int p = (o - 3 * V_CYC - HS_CYC) % PIX_CYC;
                    in_read = 1'b1;
                    ela = 1'b1;
                    eh1 = (p < PIX_CYC / 2);
                    eval = (p == VAL_OFS);
                    erg = (p < RST_W);
                end
            end else if (n >= integ) begin
                rq = "R9";
            end
            if (integ == 0 && n == 0) chk(v1, 1'b1, "R11", "v1 immediate", n);
            chk(v1, ev1, rq, "v1", n);
            chk(v2, ev2, rq, "v2", n);
            chk(frame_active, efa, rq, "frame_active", n);
            chk(line_active, ela, "R4", "line_active", n);
            chk(h1, eh1, in_read ? "R5" : "R3", "h1", n);
            chk(h1_last, eh1, in_read ? "R5" : "R3", "h1_last", n);
            chk(h2, ~eh1, "R5", "h2", n);
            chk(pix_valid, eval, "R8", "pix_valid", n);
            if (in_read) chk(rst_gate, erg, "R7", "rst_gate in read", n);
            if (inj >= 0 && n > inj + 1 && n >= integ + LINES * LINE_CYC)
                chk(frame_active, 1'b0, "R10", "no second frame", n);
            if (v1 && !prev_v1) begin
                rises++;
                if (last_rise >= 0) chk_int(n - last_rise, LINE_CYC, "R6", "line period");
                last_rise = n;
            end
            prev_v1 = v1;
            if (n == inj) start = 1'b1;
            else          start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk_int(rises, LINES, "R9", "lines per frame");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int highs = 0;
        repeat (3) @(negedge clk);
        chk(v1, 1'b0, "R1", "reset v1", 0);
        chk(v2, 1'b0, "R1", "reset v2", 0);
        chk(frame_active, 1'b0, "R1", "reset frame_active", 0);
        chk(line_active, 1'b0, "R1", "reset line_active", 0);
        chk(pix_valid, 1'b0, "R8", "reset pix_valid", 0);
        chk(h1, 1'b1, "R1", "reset h1", 0);
        @(negedge clk) rst_n = 1'b1;
        // R7: reset gate keeps pulsing while idle
        for (int i = 0; i < 8 * PIX_CYC; i++) begin
            @(negedge clk);
            if (rst_gate) highs++;
        end
        chk_int(highs, 8 * RST_W, "R7", "idle reset gate duty");
        run_frame(0, -1);
        run_frame(5, 3);
        run_frame(2, 40);
        run_frame(11, 70);
        run_frame(1, LINE_CYC * 2 + 15);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule